// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a simple request/ready host port to a 32-bit fast page mode DRAM array of 16M words. A 24-bit word address is split into a 12-bit row, driven when RAS falls, and a 12-bit column, driven when the CAS strobes fall. Each of the four CAS strobes gates one byte lane of the data word, so partial writes touch only the enabled bytes. Writes use early-write sequencing: the write enable and the data bus go active in the same cycle that CAS falls and stay active until CAS rises.

After an access the row stays open. A later request to the same row gets a page-mode column cycle without a new RAS cycle. The page is closed, with RAS and every CAS high, when one of three things happens: a request arrives for another row, a refresh request is raised, or the open-row timer comes close to the page-mode RAS limit. Refresh uses a request/grant handshake. The grant means the controller has parked the bus with RAS precharged, and it does not accept host requests until the request drops.

Every timing limit is a parameter in nanoseconds. Each one is converted to clock cycles, rounding up, for the clock period parameter.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row address `reqAddr[23:12]` is on `dramAddr` from the cycle RAS falls until CAS falls. The column address `reqAddr[11:0]` is on `dramAddr` and holds steady for as long as any CAS strobe is low.
- R2: During a write, `dramCasN[i]` goes low only when `reqByteEn[i]` is set, and bit i covers data bits `8*i+7:8*i`. During a read, all four strobes go low.
- R3: Before any falling edge, RAS stays high for at least ceil(T_RP_NS/CLK_NS) cycles (3 at the default settings).
- R4: CAS falls at least ceil(T_RCD_NS/CLK_NS) cycles after RAS falls (2 by default). Each CAS low pulse lasts at least ceil(T_CAS_NS/CLK_NS) cycles (2 by default).
- R5: For a write, `dramWeN` is low and `dramDqOe` is high during exactly the cycles in which CAS is low. `dramWeN` never falls while CAS is already low. A read never drives the data bus.
- R6: A read answers with a one-cycle `rspValid` pulse in the first cycle after CAS rises. `rspRData` carries `dramDqIn` as sampled in the last CAS-low cycle, which comes only after at least 2 CAS-low cycles and 5 RAS-low cycles.
- R7: A request to the open row is served by a column cycle with no new RAS fall. Between page-mode column cycles CAS stays high for at least 1 cycle, and successive CAS falls are at least ceil(T_PC_NS/CLK_NS) cycles apart (4 by default).
- R8: A request to a different row raises RAS, waits out the R3 precharge, and then opens the new row.
- R9: RAS never stays low for more than ceil(T_RASP_NS/CLK_NS) cycles. When the open-row timer nears that limit, the page is closed even if no request is waiting.
- R10: When `refReq` is high, the open page is closed. `refGnt` rises only after the R3 precharge, and while it is high RAS and all CAS strobes stay high and no request is accepted.
- R11: After reset, RAS, all CAS strobes and `dramWeN` are high, `dramDqOe`, `rspValid` and `refGnt` are low, and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Request accepted at this clock edge when valid |
| reqAddr | input | 24 | Word address, row in upper 12 bits |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByteEn | input | 4 | Byte lane enables for writes |
| reqWData | input | 32 | Write data |
| rspValid | output | 1 | Read data valid pulse |
| rspRData | output | 32 | Read data |
| refReq | input | 1 | Refresh arbiter requests the bus |
| refGnt | output | 1 | Bus parked and precharged for refresh |
| dramAddr | output | 12 | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 4 | Per-byte column strobes, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramDqOut | output | 32 | Data to the array |
| dramDqOe | output | 1 | Data bus drive enable |
| dramDqIn | input | 32 | Data from the array |

## Verification
A wrong state in the sequencer shows up on the strobes within a cycle or two. A skipped row phase puts CAS down too soon after RAS, a lost precharge count shortens the high time of RAS before its next fall, and a missed page-hit decision appears as an extra RAS fall at the port. Errors in the datapath show up differently. A wrong byte-lane mask or early-write timing is visible as soon as CAS falls, and a read capture taken too early returns the model's filler word instead of the stored data. A broken page timer needs the full timer window before it can be seen, so the bench shortens that limit and then watches for RAS to rise on its own.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PAGE,
    ST_REF
  } ctrlState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // latch the accepted request
    logic selRow;   // drive row address
    logic casOn;    // column strobe phase
    logic capture;  // last CAS-low cycle of the access
  } dpStrobe_t;

  function automatic int nsToCyc(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DRAM_AW = 12,
  parameter int DATA_W  = 32,
  parameter int LANES   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [LANES-1:0]  reqByteEn,
  input  logic [DATA_W-1:0] reqWData,
  output logic              rowHit,
  output logic [DRAM_AW-1:0] dramAddr,
  output logic [LANES-1:0]  dramCasN,
  output logic              dramWeN,
  output logic [DATA_W-1:0] dramDqOut,
  output logic              dramDqOe,
  input  logic [DATA_W-1:0] dramDqIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRData
);

  logic [DRAM_AW-1:0] rowQ, colQ;
  logic [LANES-1:0]   beQ;
  logic               wrQ;
  logic [DATA_W-1:0]  wdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ     <= '0;
      colQ     <= '0;
      beQ      <= '0;
      wrQ      <= 1'b0;
      wdQ      <= '0;
      rspValid <= 1'b0;
      rspRData <= '0;
    end else begin
      if (strobe.load) begin
        rowQ <= reqAddr[ADDR_W-1 -: DRAM_AW];
        colQ <= reqAddr[DRAM_AW-1:0];
        beQ  <= reqByteEn;
        wrQ  <= reqWrite;
        wdQ  <= reqWData;
      end
      rspValid <= strobe.capture && !wrQ;
      if (strobe.capture && !wrQ) rspRData <= dramDqIn;
    end
  end

  assign rowHit    = (reqAddr[ADDR_W-1 -: DRAM_AW] == rowQ);
  assign dramAddr  = strobe.selRow ? rowQ : colQ;
  assign dramWeN   = !(strobe.casOn && wrQ);
  assign dramDqOe  = strobe.casOn && wrQ;
  assign dramDqOut = wdQ;

  // one strobe per byte lane; reads open every lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign dramCasN[g] = !(strobe.casOn && (!wrQ || beQ[g]));
  end

endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int RP_CYC     = 3,
  parameter int RCD_CYC    = 2,
  parameter int CAS_CYC    = 2,
  parameter int RAC_CYC    = 5,
  parameter int RASMIN_CYC = 5,
  parameter int CPE_CYC    = 2,
  parameter int RASP_CYC   = 20000,
  parameter int GUARD_CYC  = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      rowHit,
  output logic      reqReady,
  input  logic      refReq,
  output logic      refGnt,
  output logic      dramRasN,
  output dpStrobe_t strobe
);

  localparam int CW = $clog2(RASP_CYC + 2);
  localparam logic [CW-1:0] RP_L    = CW'(RP_CYC);
  localparam logic [CW-1:0] RCD_L   = CW'(RCD_CYC - 1);
  localparam logic [CW-1:0] CAS_L   = CW'(CAS_CYC - 1);
  localparam logic [CW-1:0] RAC_L   = CW'(RAC_CYC - 1);
  localparam logic [CW-1:0] RMIN_L  = CW'(RASMIN_CYC - 1);
  localparam logic [CW-1:0] CPE_L   = CW'(CPE_CYC - 1);
  localparam logic [CW-1:0] PAGE_L  = CW'(RASP_CYC - GUARD_CYC);

  ctrlState_t state;
  logic [CW-1:0] stCnt, rasCnt, preCnt;
  logic canStart, pageOk, cpDone, closeNow, hitGo, accept, colDone, refGo;

  always_comb begin
    pageOk   = rasCnt < PAGE_L;
    cpDone   = stCnt >= CPE_L;
    canStart = (state == ST_IDLE) && (preCnt >= RP_L) && !refReq;
    refGo    = (state == ST_IDLE) && (preCnt >= RP_L) && refReq;
    hitGo    = (state == ST_PAGE) && cpDone && pageOk && !refReq && rowHit;
    closeNow = (state == ST_PAGE) && cpDone && (rasCnt >= RMIN_L) &&
               (!pageOk || refReq || (reqValid && !rowHit));
    reqReady = canStart || hitGo;
    accept   = reqReady && reqValid;
    colDone  = (state == ST_COL) && (stCnt >= CAS_L) && (rasCnt >= RAC_L);

    strobe.load    = accept;
    strobe.selRow  = (state == ST_ROW);
    strobe.casOn   = (state == ST_COL);
    strobe.capture = colDone;
    refGnt   = (state == ST_REF);
    dramRasN = !(state inside {ST_ROW, ST_COL, ST_PAGE});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      stCnt  <= '0;
      rasCnt <= '0;
      preCnt <= RP_L;
    end else begin
      if (state inside {ST_ROW, ST_COL, ST_PAGE}) begin
        if (rasCnt != '1) rasCnt <= rasCnt + 1'b1;
      end else begin
        rasCnt <= '0;
      end
      if (stCnt != '1) stCnt <= stCnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (preCnt != '1) preCnt <= preCnt + 1'b1;
          if (accept) begin
            state <= ST_ROW;
            stCnt <= '0;
          end else if (refGo) begin
            state <= ST_REF;
          end
        end
        ST_ROW: begin
          if (stCnt >= RCD_L) begin
            state <= ST_COL;
            stCnt <= '0;
          end
        end
        ST_COL: begin
          if (colDone) begin
            state <= ST_PAGE;
            stCnt <= '0;
          end
        end
        ST_PAGE: begin
          if (closeNow) begin
            state  <= ST_IDLE;
            preCnt <= CW'(1);
          end else if (accept) begin
            state <= ST_COL;
            stCnt <= '0;
          end
        end
        ST_REF: begin
          if (!refReq) begin
            state  <= ST_IDLE;
            preCnt <= CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DRAM_AW   = 12,
  parameter int DATA_W    = 32,
  parameter int CLK_NS    = 10,
  parameter int T_RP_NS   = 30,
  parameter int T_RCD_NS  = 13,
  parameter int T_CAS_NS  = 13,
  parameter int T_CP_NS   = 10,
  parameter int T_PC_NS   = 35,
  parameter int T_RAC_NS  = 50,
  parameter int T_RAS_NS  = 50,
  parameter int T_RASP_NS = 200000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W/8-1:0] reqByteEn,
  input  logic [DATA_W-1:0] reqWData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRData,
  input  logic              refReq,
  output logic              refGnt,
  output logic [DRAM_AW-1:0] dramAddr,
  output logic              dramRasN,
  output logic [DATA_W/8-1:0] dramCasN,
  output logic              dramWeN,
  output logic [DATA_W-1:0] dramDqOut,
  output logic              dramDqOe,
  input  logic [DATA_W-1:0] dramDqIn
);

  localparam int LANES      = DATA_W / 8;
  localparam int RP_CYC     = nsToCyc(T_RP_NS, CLK_NS);
  localparam int RCD_CYC    = nsToCyc(T_RCD_NS, CLK_NS);
  localparam int CAS_CYC    = nsToCyc(T_CAS_NS, CLK_NS);
  localparam int CP_CYC     = nsToCyc(T_CP_NS, CLK_NS);
  localparam int PC_CYC     = nsToCyc(T_PC_NS, CLK_NS);
  localparam int RAC_CYC    = nsToCyc(T_RAC_NS, CLK_NS);
  localparam int RASMIN_CYC = nsToCyc(T_RAS_NS, CLK_NS);
  localparam int RASP_CYC   = T_RASP_NS / CLK_NS;
  localparam int CPE_CYC    = maxInt(CP_CYC, PC_CYC - CAS_CYC);
  localparam int GUARD_CYC  = maxInt(CAS_CYC, RAC_CYC) + CPE_CYC + 2;

  dpStrobe_t strobe;
  logic      rowHit;

  fpm_ctrl #(
    .RP_CYC(RP_CYC), .RCD_CYC(RCD_CYC), .CAS_CYC(CAS_CYC), .RAC_CYC(RAC_CYC),
    .RASMIN_CYC(RASMIN_CYC), .CPE_CYC(CPE_CYC), .RASP_CYC(RASP_CYC),
    .GUARD_CYC(GUARD_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit),
    .reqReady(reqReady), .refReq(refReq), .refGnt(refGnt),
    .dramRasN(dramRasN), .strobe(strobe)
  );

  fpm_datapath #(
    .ADDR_W(ADDR_W), .DRAM_AW(DRAM_AW), .DATA_W(DATA_W), .LANES(LANES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqByteEn(reqByteEn), .reqWData(reqWData),
    .rowHit(rowHit), .dramAddr(dramAddr), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramDqOut(dramDqOut), .dramDqOe(dramDqOe),
    .dramDqIn(dramDqIn), .rspValid(rspValid), .rspRData(rspRData)
  );

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk
  import fpm_pkg::*;
#(
  parameter int DRAM_AW   = 12,
  parameter int LANES     = 4,
  parameter int CLK_NS    = 10,
  parameter int T_RP_NS   = 30,
  parameter int T_RCD_NS  = 13,
  parameter int T_CAS_NS  = 13,
  parameter int T_RASP_NS = 200000
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqReady,
  input logic               rspValid,
  input logic               refGnt,
  input logic [DRAM_AW-1:0] dramAddr,
  input logic               dramRasN,
  input logic [LANES-1:0]   dramCasN,
  input logic               dramWeN,
  input logic               dramDqOe
);

  localparam int RP_CYC   = nsToCyc(T_RP_NS, CLK_NS);
  localparam int RCD_CYC  = nsToCyc(T_RCD_NS, CLK_NS);
  localparam int CAS_CYC  = nsToCyc(T_CAS_NS, CLK_NS);
  localparam int RASP_CYC = T_RASP_NS / CLK_NS;
  localparam int CW       = $clog2(RASP_CYC + 2);

  logic [CW-1:0] hiRun, loRun, casRun;
  logic casAny;
  assign casAny = !(&dramCasN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun  <= CW'(RP_CYC);
      loRun  <= '0;
      casRun <= '0;
    end else begin
      hiRun  <= dramRasN ? ((hiRun != '1) ? hiRun + 1'b1 : hiRun) : '0;
      loRun  <= !dramRasN ? ((loRun != '1) ? loRun + 1'b1 : loRun) : '0;
      casRun <= casAny ? ((casRun != '1) ? casRun + 1'b1 : casRun) : '0;
    end
  end

  assert_precharge_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> hiRun >= CW'(RP_CYC));
  assert_ras_to_cas_R4: assert property (@(posedge clk) disable iff (!rstN)
    (casAny && $past(!casAny)) |-> loRun >= CW'(RCD_CYC));
  assert_cas_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!casAny && $past(casAny)) |-> casRun >= CW'(CAS_CYC));
  assert_cas_under_ras_R1: assert property (@(posedge clk) disable iff (!rstN)
    casAny |-> !dramRasN);
  assert_col_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (casAny && $past(casAny)) |-> $stable(dramAddr));
  assert_we_early_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramWeN) |-> (&$past(dramCasN)));
  assert_drive_only_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    dramDqOe |-> (!dramWeN && casAny));
  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  assert_page_limit_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dramRasN |-> loRun < CW'(RASP_CYC));
  assert_ref_parked_R10: assert property (@(posedge clk) disable iff (!rstN)
    refGnt |-> (dramRasN && !casAny && !reqReady));

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .DRAM_AW(DRAM_AW), .LANES(DATA_W / 8), .CLK_NS(CLK_NS), .T_RP_NS(T_RP_NS),
  .T_RCD_NS(T_RCD_NS), .T_CAS_NS(T_CAS_NS), .T_RASP_NS(T_RASP_NS)
) chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .refGnt(refGnt), .dramAddr(dramAddr), .dramRasN(dramRasN),
  .dramCasN(dramCasN), .dramWeN(dramWeN), .dramDqOe(dramDqOe)
);

// File: tb/fpm_dram_ctrl_tb_top.sv
module fpm_dram_ctrl_tb_top;

  localparam int RP = 3, RCD = 2, CASC = 2, RAC = 5, PCC = 4, RASPC = 200;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, reqValid, reqReady, reqWrite, rspValid, refReq, refGnt;
  logic [23:0] reqAddr;
  logic [3:0]  reqByteEn, dramCasN;
  logic [31:0] reqWData, rspRData, dramDqOut, dramDqIn;
  logic [11:0] dramAddr;
  logic dramRasN, dramWeN, dramDqOe;

  fpm_dram_ctrl #(.T_RASP_NS(2000)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqByteEn(reqByteEn),
    .reqWData(reqWData), .rspValid(rspValid), .rspRData(rspRData),
    .refReq(refReq), .refGnt(refGnt), .dramAddr(dramAddr),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural array model and timing monitor, sampled on the falling edge
  logic [31:0] mem [64];
  logic [31:0] shadow [64];
  logic [2:0]  mRow;
  logic [11:0] expRow;
  logic        prevRasN = 1'b1, firstCas = 1'b0;
  logic [3:0]  prevCas = 4'hF;
  int hiRun = 100, loRun = 0, casLoRun = 0, casHiRun = 100, sinceFall = 100;
  int rasFalls = 0, maxLo = 0;

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; shadow[i] = '0; end
    dramDqIn = '0;
  end

  always @(negedge clk) begin
    if (rstN) begin
      sinceFall++;
      if (prevRasN && !dramRasN) begin
        rasFalls++;
        mRow = dramAddr[2:0];
        firstCas = 1'b1;
        chk(hiRun >= RP, "R3 precharge", hiRun, RP);
        chk(dramAddr == expRow, "R1 row addr", dramAddr, expRow);
      end
      if (dramRasN) hiRun++; else hiRun = 0;
      if (!dramRasN) loRun++; else loRun = 0;
      if (loRun > maxLo) maxLo = loRun;
      if ((&prevCas) && !(&dramCasN)) begin
        if (firstCas) chk(loRun - 1 >= RCD, "R4 ras-to-cas", loRun - 1, RCD);
        else begin
          chk(sinceFall >= PCC, "R7 page cycle", sinceFall, PCC);
          chk(casHiRun >= 1, "R7 cas precharge", casHiRun, 1);
        end
        firstCas = 1'b0;
        sinceFall = 0;
        if (!dramWeN)
          for (int l = 0; l < 4; l++)
            if (!dramCasN[l]) mem[{mRow, dramAddr[2:0]}][l*8 +: 8] = dramDqOut[l*8 +: 8];
      end
      if (!(&prevCas) && (&dramCasN)) chk(casLoRun >= CASC, "R4 cas width", casLoRun, CASC);
      if (!(&dramCasN)) begin casLoRun++; casHiRun = 0; end
      else begin casLoRun = 0; casHiRun++; end
      dramDqIn = (!(&dramCasN) && dramWeN && casLoRun >= CASC && loRun >= RAC)
                 ? mem[{mRow, dramAddr[2:0]}] : 32'hDEAD_BEEF;
      prevRasN = dramRasN;
      prevCas  = dramCasN;
    end
  end

  task automatic access(input bit wr, input logic [3:0] be, input logic [23:0] addr,
                        input logic [31:0] data, input bit newRow);
    int f0;
    logic [31:0] exp;
    int idx;
    idx = {addr[14:12], addr[2:0]};
    f0 = rasFalls;
    expRow = addr[23:12];
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqByteEn = be; reqAddr = addr; reqWData = data;
    #0;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1 reqValid = 1'b0;
    @(negedge clk);
    while (&dramCasN) @(negedge clk);
    chk(dramAddr == addr[11:0], "R1 col addr", dramAddr, addr[11:0]);
    chk(dramCasN == (wr ? ~be : 4'h0), "R2 lane strobes", dramCasN, wr ? ~be : 4'h0);
    chk(dramWeN == !wr && dramDqOe == wr, "R5 write enable/drive",
        {dramWeN, dramDqOe}, {!wr, wr});
    if (wr) chk(dramDqOut == data, "R5 write data", dramDqOut, data);
    while (!(&dramCasN)) @(negedge clk);
    chk(rspValid == !wr, "R6 rsp pulse", rspValid, !wr);
    if (wr) begin
      for (int l = 0; l < 4; l++) if (be[l]) shadow[idx][l*8 +: 8] = data[l*8 +: 8];
    end else begin
      exp = shadow[idx];
      chk(rspRData == exp, "R6 read data", rspRData, exp);
    end
    chk((rasFalls - f0) == int'(newRow), newRow ? "R8 row open" : "R7 page hit",
        rasFalls - f0, newRow);
  endtask

  localparam int NV = 11;
  localparam logic [61:0] VEC [NV] = '{
    {1'b1, 4'hF, 24'h001002, 32'hA1A2A3A4, 1'b1},
    {1'b0, 4'hF, 24'h001002, 32'h0,        1'b0},
    {1'b1, 4'h5, 24'h001002, 32'h11223344, 1'b0},
    {1'b0, 4'hF, 24'h001002, 32'h0,        1'b0},
    {1'b1, 4'hF, 24'h002005, 32'h55667788, 1'b1},
    {1'b0, 4'hF, 24'h001002, 32'h0,        1'b1},
    {1'b0, 4'hF, 24'h002005, 32'h0,        1'b1},
    {1'b1, 4'h8, 24'h002005, 32'hEE000000, 1'b0},
    {1'b0, 4'hF, 24'h002005, 32'h0,        1'b0},
    {1'b1, 4'hF, 24'h003007, 32'hCAFE0123, 1'b1},
    {1'b0, 4'hF, 24'h003007, 32'h0,        1'b0}
  };

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqByteEn = '0;
    reqAddr = '0; reqWData = '0; refReq = 1'b0; expRow = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(dramRasN && (&dramCasN) && dramWeN, "R11 strobes idle", {dramRasN, dramCasN, dramWeN}, 6'h3F);
    chk(!dramDqOe && !rspValid && !refGnt, "R11 outputs quiet", {dramDqOe, rspValid, refGnt}, 0);
    chk(reqReady, "R11 ready", reqReady, 1);

    for (int v = 0; v < NV; v++)
      access(VEC[v][61], VEC[v][60:57], VEC[v][56:33], VEC[v][32:1], VEC[v][0]);

    // R10 refresh closes page, parks bus, blocks requests
    begin
      int f0;
      int n = 0;
      @(negedge clk);
      refReq = 1'b1;
      while (!refGnt && n < 50) begin @(negedge clk); n++; end
      chk(refGnt, "R10 grant", refGnt, 1);
      chk(dramRasN && (&dramCasN), "R10 bus parked", {dramRasN, dramCasN}, 5'h1F);
      f0 = rasFalls;
      reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 24'h001002; reqByteEn = 4'hF;
      repeat (6) @(negedge clk);
      chk(!reqReady && rasFalls == f0, "R10 requests held", {reqReady, 8'(rasFalls - f0)}, 0);
      reqValid = 1'b0;
      refReq = 1'b0;
    end
    access(1'b0, 4'hF, 24'h003007, 32'h0, 1'b1);

    // R9 page timer closes an idle open row
    access(1'b0, 4'hF, 24'h001002, 32'h0, 1'b1);
    repeat (300) @(negedge clk);
    chk(dramRasN, "R9 page closed", dramRasN, 1);
    chk(maxLo <= RASPC, "R9 ras low bound", maxLo, RASPC);
    access(1'b0, 4'hF, 24'h001002, 32'h0, 1'b1);

    done = 1;
    finishRun();
  end

endmodule